// File: doc/BRIEF.md
# IEEE 802.15.4 Receive Frame Filter

This block inspects every received IEEE 802.15.4 MAC frame as its bytes stream in from the demodulator. It decides whether the frame is addressed to this node. A start strobe carries the PHY length byte. Each MAC byte that follows, from the frame control field through the FCS, arrives with a byte-valid strobe. An end strobe closes the frame and carries the result of an external FCS check.

The filter holds the node's PAN identifier, its 16-bit short address and its 64-bit extended address. It also holds one accept enable per frame class, a PAN-coordinator flag and a bypass that disables address filtering. It captures only the header fields it needs. The field offsets are derived from the addressing modes as the frame arrives.

When the end strobe arrives, the block produces three one-cycle verdict pulses:
- a frame-type pulse, when the frame class is enabled;
- an address-match pulse, when the frame passes every filtering rule;
- a packet-received pulse, when the frame passes the filter and the FCS is good.

Top module: `rx_frame_filter`

## Requirements
- R1: After a synchronous active-low reset, `frame_type_ok`, `addr_match` and `pkt_rcvd` are all low.
- R2: The frame control field is sent low byte first, with these fields:
  - bits [2:0] frame type: 0 beacon, 1 data, 2 acknowledgement, 3 command, 4–7 reserved;
  - bit 6 PAN ID compression;
  - bits [11:10] destination addressing mode;
  - bits [13:12] frame version;
  - bits [15:14] source addressing mode.

  `frame_type_ok` pulses when both control bytes have arrived and the accept bit of the frame's class is set. The accept bits in `cfg_type_accept` are: bit 0 beacon, bit 1 data, bit 2 acknowledgement, bit 3 command, bit 4 reserved types 4–7.
- R3: With address filtering on, a frame whose version is 3, or whose destination or source addressing mode is 1, never produces `addr_match`.
- R4: When a destination address is present, the destination PAN field must equal `cfg_pan_id` or 0xFFFF.
- R5: A short destination address (mode 2) must equal `cfg_short_addr` or 0xFFFF. An extended destination address (mode 3) must equal all 64 bits of `cfg_ext_addr`, and its first byte on air is the least significant byte.
- R6: A beacon matches only if all of the following hold:
  - its destination mode is 0;
  - its source mode is 2 or 3;
  - its source PAN equals `cfg_pan_id`, or `cfg_pan_id` is 0xFFFF, in which case any source PAN passes.
- R7: Data, command and reserved-type frames must carry a destination address, a source address, or both. With no destination address, the frame matches only when `cfg_pan_coord` is set and the source PAN equals `cfg_pan_id`.
- R8: Bit 7 of the length byte is cleared before use. An acknowledgement frame matches only if the remaining 7-bit length equals 5.
- R9: The header layout after the 1-byte sequence number is:
  - destination PAN (2 bytes, present when the destination mode is nonzero);
  - destination address (0, 2 or 8 bytes);
  - source PAN (2 bytes, present when the source mode is nonzero, unless compression is set and a destination address is present);
  - source address (0, 2 or 8 bytes).

  When the source PAN is omitted because of compression, the destination PAN stands in for it.
- R10: A frame that ends before its whole addressing header has arrived never produces `addr_match` or `pkt_rcvd`.
- R11: With `cfg_accept_any` set, no address or integrity rule applies and `addr_match` stays low. `pkt_rcvd` then equals the type verdict ANDed with `fcs_ok`.
- R12: All three outputs are registered and pulse for exactly the one cycle after the clock edge that samples `frm_end`. `addr_match` ignores `fcs_ok`, and `pkt_rcvd` requires both a filter pass and `fcs_ok`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frm_start | input | 1 | Start of frame; `byte_data` carries the length byte |
| byte_vld | input | 1 | A MAC byte is on `byte_data` |
| byte_data | input | 8 | Length byte or MAC byte |
| frm_end | input | 1 | End of frame strobe |
| fcs_ok | input | 1 | FCS result, sampled with `frm_end` |
| cfg_pan_id | input | 16 | Node PAN identifier |
| cfg_short_addr | input | 16 | Node short address |
| cfg_ext_addr | input | 64 | Node extended address |
| cfg_type_accept | input | 5 | Per-class accept enables |
| cfg_accept_any | input | 1 | Disable address filtering |
| cfg_pan_coord | input | 1 | Node is PAN coordinator |
| frame_type_ok | output | 1 | Frame class allowed pulse |
| addr_match | output | 1 | Filter pass pulse |
| pkt_rcvd | output | 1 | Filter pass with good FCS pulse |

## Verification
The assertions assume these input rules:
- `frm_end` is a single-cycle strobe, never on two consecutive cycles, and never in the same cycle as `frm_start` or `byte_vld`;
- the configuration is stable from a frame's start until its verdict.

The bench drives one event per cycle at the falling edge and leaves at least one idle cycle after each end strobe. It changes the configuration only between frames, so every stimulus respects these rules. The sweeps cover every frame type, version, addressing-mode pair and compression setting under three configurations, with rotating address and PAN matches and FCS values.

// File: rtl/rxf_pkg.sv
// Shared constants, types and helpers for the receive frame filter.
// Assumes standard 802.15.4 field sizes (2-byte PAN, 2/8-byte addresses).
package rxf_pkg;

    localparam int BYTE_W     = 8;
    localparam int PAN_W      = 16;
    localparam int SHORT_W    = 16;
    localparam int EXT_BYTES  = 8;
    localparam int EXT_W      = EXT_BYTES * BYTE_W;
    localparam int LEN_W      = 7;
    localparam int PAN_BYTES  = PAN_W / BYTE_W;
    localparam int HDR_FIXED  = 3;           // two control bytes and the sequence number
    localparam int NUM_CLS    = 5;
    localparam int ACK_LEN    = 5;
    localparam logic [PAN_W-1:0] BCAST = '1;

    localparam logic [1:0] AM_NONE  = 2'd0;
    localparam logic [1:0] AM_RSVD  = 2'd1;
    localparam logic [1:0] AM_SHORT = 2'd2;
    localparam logic [1:0] AM_EXT   = 2'd3;
    localparam logic [1:0] VER_RSVD = 2'd3;

    typedef enum logic [2:0] {
        CLS_BEACON = 3'd0,
        CLS_DATA   = 3'd1,
        CLS_ACK    = 3'd2,
        CLS_CMD    = 3'd3,
        CLS_RSVD   = 3'd4
    } frm_class_e;

    // Only the control-field bits the filter actually uses.
    typedef struct packed {
        logic [1:0] src_mode;
        logic [1:0] version;
        logic [1:0] dst_mode;
        logic       pan_comp;
        logic [2:0] ftype;
    } fcf_view_t;

    // Number of address bytes carried for an addressing mode.
    function automatic logic [3:0] mode_bytes(input logic [1:0] mode);
        case (mode)
            AM_EXT:   mode_bytes = 4'(EXT_BYTES);
            AM_SHORT: mode_bytes = 4'(SHORT_W / BYTE_W);
            default:  mode_bytes = 4'd0;
        endcase
    endfunction

endpackage

// File: rtl/rxf_fcf_decode.sv
// Combinational decode of the captured control-field bits: frame class,
// integrity, field presence and the byte offsets of every addressing field.
// Assumes fcf is stable once the two control bytes have been captured.
module rxf_fcf_decode
    import rxf_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  fcf_view_t           fcf,
    output frm_class_e          cls,
    output logic                integ_ok,
    output logic                dst_present,
    output logic                src_present,
    output logic                src_pan_present,
    output logic [3:0]          dst_len,
    output logic [CNT_W-1:0]    dst_addr_off,
    output logic [CNT_W-1:0]    src_pan_off,
    output logic [CNT_W-1:0]    hdr_len
);

    logic [3:0] src_len;

    // Class, integrity and presence of each field.
    always_comb begin
        cls             = (fcf.ftype > 3'd3) ? CLS_RSVD : frm_class_e'(fcf.ftype);
        integ_ok        = (fcf.version != VER_RSVD) && (fcf.dst_mode != AM_RSVD)
                          && (fcf.src_mode != AM_RSVD);
        dst_present     = (fcf.dst_mode != AM_NONE);
        src_present     = (fcf.src_mode != AM_NONE);
        src_pan_present = src_present && !(fcf.pan_comp && dst_present);
        dst_len         = mode_bytes(fcf.dst_mode);
        src_len         = mode_bytes(fcf.src_mode);
    end

    // Running byte offsets of the addressing fields.
    always_comb begin
        dst_addr_off = CNT_W'(HDR_FIXED) + (dst_present ? CNT_W'(PAN_BYTES) : '0);
        src_pan_off  = dst_addr_off + CNT_W'(dst_len);
        hdr_len      = src_pan_off + (src_pan_present ? CNT_W'(PAN_BYTES) : '0)
                       + CNT_W'(src_len);
    end

endmodule

// File: rtl/rxf_field_capture.sv
// Counts the MAC bytes of the current frame and captures the length byte,
// the control-field bits, the destination PAN and address, and the source PAN.
// Assumes frm_end never shares a cycle with byte_vld or frm_start.
module rxf_field_capture
    import rxf_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                frm_start,
    input  logic                frm_end,
    input  logic                byte_vld,
    input  logic [BYTE_W-1:0]   byte_data,
    input  logic                dst_present,
    input  logic                src_pan_present,
    input  logic [3:0]          dst_len,
    input  logic [CNT_W-1:0]    dst_addr_off,
    input  logic [CNT_W-1:0]    src_pan_off,
    output logic                in_frame,
    output logic [CNT_W-1:0]    byte_cnt,
    output logic [LEN_W-1:0]    len_q,
    output fcf_view_t           fcf_q,
    output logic [PAN_W-1:0]    dst_pan,
    output logic [EXT_W-1:0]    dst_addr,
    output logic [PAN_W-1:0]    src_pan
);

    logic take;
    assign take = in_frame && byte_vld && !frm_start;

    // Frame window, byte counter and the length byte with bit 7 dropped.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_frame <= 1'b0;
            byte_cnt <= '0;
            len_q    <= '0;
        end else if (frm_start) begin
            in_frame <= 1'b1;
            byte_cnt <= '0;
            len_q    <= byte_data[LEN_W-1:0];
        end else if (frm_end) begin
            in_frame <= 1'b0;
        end else if (take && (byte_cnt != '1)) begin
            byte_cnt <= byte_cnt + 1'b1;
        end
    end

    // Control-field bits from the first two MAC bytes.
    always_ff @(posedge clk) begin
        if (!rst_n || frm_start) begin
            fcf_q <= '0;
        end else if (take && byte_cnt == CNT_W'(0)) begin
            fcf_q.ftype    <= byte_data[2:0];
            fcf_q.pan_comp <= byte_data[6];
        end else if (take && byte_cnt == CNT_W'(1)) begin
            fcf_q.dst_mode <= byte_data[3:2];
            fcf_q.version  <= byte_data[5:4];
            fcf_q.src_mode <= byte_data[7:6];
        end
    end

    // Destination PAN and source PAN, each little-endian.
    always_ff @(posedge clk) begin
        if (!rst_n || frm_start) begin
            dst_pan <= '0;
            src_pan <= '0;
        end else if (take) begin
            if (dst_present && byte_cnt == CNT_W'(HDR_FIXED))
                dst_pan[7:0] <= byte_data;
            if (dst_present && byte_cnt == CNT_W'(HDR_FIXED + 1))
                dst_pan[15:8] <= byte_data;
            if (src_pan_present && byte_cnt == src_pan_off)
                src_pan[7:0] <= byte_data;
            if (src_pan_present && byte_cnt == src_pan_off + CNT_W'(1))
                src_pan[15:8] <= byte_data;
        end
    end

    // One capture slot per destination address byte, least significant first.
    for (genvar k = 0; k < EXT_BYTES; k++) begin : g_slot
        logic [BYTE_W-1:0] slot_q;
        always_ff @(posedge clk) begin
            if (!rst_n || frm_start)
                slot_q <= '0;
            else if (take && (4'(k) < dst_len) && byte_cnt == dst_addr_off + CNT_W'(k))
                slot_q <= byte_data;
        end
        assign dst_addr[k*BYTE_W +: BYTE_W] = slot_q;
    end

endmodule

// File: rtl/rxf_rule_eval.sv
// Combinational filtering rules on the captured fields: type verdict and
// full address/integrity verdict. Assumes configuration stable during a frame.
module rxf_rule_eval
    import rxf_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic [PAN_W-1:0]    cfg_pan_id,
    input  logic [SHORT_W-1:0]  cfg_short_addr,
    input  logic [EXT_W-1:0]    cfg_ext_addr,
    input  logic [NUM_CLS-1:0]  cfg_type_accept,
    input  logic                cfg_pan_coord,
    input  frm_class_e          cls,
    input  logic [1:0]          dst_mode,
    input  logic [1:0]          src_mode,
    input  logic                pan_comp,
    input  logic                integ_ok,
    input  logic                dst_present,
    input  logic                src_present,
    input  logic [CNT_W-1:0]    hdr_len,
    input  logic [CNT_W-1:0]    byte_cnt,
    input  logic [LEN_W-1:0]    len_q,
    input  logic [PAN_W-1:0]    dst_pan,
    input  logic [EXT_W-1:0]    dst_addr,
    input  logic [PAN_W-1:0]    src_pan,
    output logic                type_ok,
    output logic                addr_ok
);

    logic [PAN_W-1:0] src_pan_eff;
    logic pan_hit, addr_hit, dst_ok, cls_rule;

    // Destination checks and the effective source PAN.
    always_comb begin
        src_pan_eff = (pan_comp && dst_present) ? dst_pan : src_pan;
        pan_hit     = (dst_pan == cfg_pan_id) || (dst_pan == BCAST);
        case (dst_mode)
            AM_SHORT: addr_hit = (dst_addr[SHORT_W-1:0] == cfg_short_addr)
                                 || (dst_addr[SHORT_W-1:0] == BCAST);
            AM_EXT:   addr_hit = (dst_addr == cfg_ext_addr);
            default:  addr_hit = 1'b0;
        endcase
        dst_ok = !dst_present || (pan_hit && addr_hit);
    end

    // Class-specific rule.
    always_comb begin
        case (cls)
            CLS_BEACON: cls_rule = !dst_present
                                   && (src_mode == AM_SHORT || src_mode == AM_EXT)
                                   && (cfg_pan_id == BCAST || src_pan_eff == cfg_pan_id);
            CLS_ACK:    cls_rule = (len_q == LEN_W'(ACK_LEN));
            default:    cls_rule = (dst_present || src_present)
                                   && (dst_present || (cfg_pan_coord && src_pan_eff == cfg_pan_id));
        endcase
    end

    // Final verdicts.
    always_comb begin
        type_ok = (byte_cnt >= CNT_W'(2)) && cfg_type_accept[cls];
        addr_ok = type_ok && integ_ok && (byte_cnt >= hdr_len) && dst_ok && cls_rule;
    end

endmodule

// File: rtl/rx_frame_filter.sv
// Top of the receive frame filter: ties capture, decode and rule logic
// together and registers the three verdict pulses on the end-of-frame strobe.
// Assumes frm_end is one cycle wide and not on consecutive cycles.
module rx_frame_filter
    import rxf_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                frm_start,
    input  logic                byte_vld,
    input  logic [7:0]          byte_data,
    input  logic                frm_end,
    input  logic                fcs_ok,
    input  logic [15:0]         cfg_pan_id,
    input  logic [15:0]         cfg_short_addr,
    input  logic [63:0]         cfg_ext_addr,
    input  logic [4:0]          cfg_type_accept,
    input  logic                cfg_accept_any,
    input  logic                cfg_pan_coord,
    output logic                frame_type_ok,
    output logic                addr_match,
    output logic                pkt_rcvd
);

    fcf_view_t          fcf_q;
    frm_class_e         cls;
    logic               integ_ok, dst_present, src_present, src_pan_present;
    logic [3:0]         dst_len;
    logic [CNT_W-1:0]   dst_addr_off, src_pan_off, hdr_len, byte_cnt;
    logic               in_frame;
    logic [LEN_W-1:0]   len_q;
    logic [PAN_W-1:0]   dst_pan, src_pan;
    logic [EXT_W-1:0]   dst_addr;
    logic               type_ok, addr_ok;

    rxf_field_capture #(.CNT_W(CNT_W)) cap_i (
        .clk(clk), .rst_n(rst_n), .frm_start(frm_start), .frm_end(frm_end),
        .byte_vld(byte_vld), .byte_data(byte_data),
        .dst_present(dst_present), .src_pan_present(src_pan_present),
        .dst_len(dst_len), .dst_addr_off(dst_addr_off), .src_pan_off(src_pan_off),
        .in_frame(in_frame), .byte_cnt(byte_cnt), .len_q(len_q), .fcf_q(fcf_q),
        .dst_pan(dst_pan), .dst_addr(dst_addr), .src_pan(src_pan)
    );

    rxf_fcf_decode #(.CNT_W(CNT_W)) dec_i (
        .fcf(fcf_q), .cls(cls), .integ_ok(integ_ok), .dst_present(dst_present),
        .src_present(src_present), .src_pan_present(src_pan_present),
        .dst_len(dst_len), .dst_addr_off(dst_addr_off), .src_pan_off(src_pan_off),
        .hdr_len(hdr_len)
    );

    rxf_rule_eval #(.CNT_W(CNT_W)) rule_i (
        .cfg_pan_id(cfg_pan_id), .cfg_short_addr(cfg_short_addr),
        .cfg_ext_addr(cfg_ext_addr), .cfg_type_accept(cfg_type_accept),
        .cfg_pan_coord(cfg_pan_coord), .cls(cls), .dst_mode(fcf_q.dst_mode),
        .src_mode(fcf_q.src_mode), .pan_comp(fcf_q.pan_comp), .integ_ok(integ_ok),
        .dst_present(dst_present), .src_present(src_present), .hdr_len(hdr_len),
        .byte_cnt(byte_cnt), .len_q(len_q), .dst_pan(dst_pan), .dst_addr(dst_addr),
        .src_pan(src_pan), .type_ok(type_ok), .addr_ok(addr_ok)
    );

    // Verdict pulses, valid for the single cycle after the end strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_type_ok <= 1'b0;
            addr_match    <= 1'b0;
            pkt_rcvd      <= 1'b0;
        end else if (frm_end && in_frame) begin
            frame_type_ok <= type_ok;
            addr_match    <= !cfg_accept_any && addr_ok;
            pkt_rcvd      <= (cfg_accept_any ? type_ok : addr_ok) && fcs_ok;
        end else begin
            frame_type_ok <= 1'b0;
            addr_match    <= 1'b0;
            pkt_rcvd      <= 1'b0;
        end
    end

endmodule

// File: rtl/rx_frame_filter_chk.sv
// Checker bound to the frame filter: relates the verdict pulses to the
// end strobe, the FCS flag and the bypass setting.
module rx_frame_filter_chk (
    input logic clk,
    input logic rst_n,
    input logic frm_end,
    input logic fcs_ok,
    input logic cfg_accept_any,
    input logic frame_type_ok,
    input logic addr_match,
    input logic pkt_rcvd
);

    a_r12_pulse_after_end: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_type_ok || addr_match || pkt_rcvd) |-> $past(frm_end));

    a_r12_rcvd_needs_fcs: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_rcvd |-> $past(fcs_ok));

    a_r12_match_needs_type: assert property (@(posedge clk) disable iff (!rst_n)
        addr_match |-> frame_type_ok);

    a_r12_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_type_ok || pkt_rcvd) |=> !(frame_type_ok || pkt_rcvd));

    a_r11_no_match_bypass: assert property (@(posedge clk) disable iff (!rst_n)
        addr_match |-> !$past(cfg_accept_any));

    a_r11_rcvd_needs_match: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_rcvd && !$past(cfg_accept_any)) |-> addr_match);

endmodule

bind rx_frame_filter rx_frame_filter_chk chk_i (
    .clk(clk), .rst_n(rst_n), .frm_end(frm_end), .fcs_ok(fcs_ok),
    .cfg_accept_any(cfg_accept_any), .frame_type_ok(frame_type_ok),
    .addr_match(addr_match), .pkt_rcvd(pkt_rcvd)
);

// File: tb/rx_frame_filter_tb_top.sv
`timescale 1ns/1ps
module rx_frame_filter_tb_top;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic frm_start = 1'b0, byte_vld = 1'b0, frm_end = 1'b0, fcs_ok = 1'b0;
    logic [7:0]  byte_data = '0;
    logic [15:0] cfg_pan_id = 16'h1A2B;
    logic [15:0] cfg_short_addr = 16'h3C4D;
    logic [63:0] cfg_ext_addr = 64'h0123_4567_89AB_CDEF;
    logic [4:0]  cfg_type_accept = 5'h1F;
    logic        cfg_accept_any = 1'b0;
    logic        cfg_pan_coord = 1'b0;
    logic        frame_type_ok, addr_match, pkt_rcvd;

    int tests = 0;
    int fails = 0;
    bit done = 0;

    logic [7:0]  fr [0:47];
    int          n;
    logic [15:0] b_dpan, b_dshort, b_span;
    logic        b_ext_ok;

    always #10 clk = ~clk;

    rx_frame_filter dut_i (
        .clk(clk), .rst_n(rst_n), .frm_start(frm_start), .byte_vld(byte_vld),
        .byte_data(byte_data), .frm_end(frm_end), .fcs_ok(fcs_ok),
        .cfg_pan_id(cfg_pan_id), .cfg_short_addr(cfg_short_addr),
        .cfg_ext_addr(cfg_ext_addr), .cfg_type_accept(cfg_type_accept),
        .cfg_accept_any(cfg_accept_any), .cfg_pan_coord(cfg_pan_coord),
        .frame_type_ok(frame_type_ok), .addr_match(addr_match), .pkt_rcvd(pkt_rcvd)
    );

    task automatic check(input string req, input logic [2:0] got, input logic [2:0] exp);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: {type,match,rcvd} got=%b expected=%b", req, got, exp);
        end
    endtask

    // Assemble a frame into fr[], remembering the field values used.
    task automatic build(input int t, input int v, input int dm, input int sm,
                         input int cp, input int vr);
        logic [15:0] fcf;
        logic [63:0] ext;
        bit spp;
        fcf = 16'(t) | 16'(cp << 6) | 16'(dm << 10) | 16'(v << 12) | 16'(sm << 14);
        b_dpan   = (vr == 1) ? 16'hFFFF : (vr == 3) ? (cfg_pan_id ^ 16'h0001) : cfg_pan_id;
        b_dshort = (vr == 1) ? 16'hFFFF : (vr == 2) ? (cfg_short_addr ^ 16'h0100) : cfg_short_addr;
        b_span   = (vr == 3) ? (cfg_pan_id ^ 16'h0010) : cfg_pan_id;
        b_ext_ok = (vr != 2);
        ext      = (vr == 2) ? (cfg_ext_addr ^ 64'h0000_0100_0000_0000) : cfg_ext_addr;
        n = 0;
        fr[n] = fcf[7:0]; n++;
        fr[n] = fcf[15:8]; n++;
        fr[n] = 8'h5A; n++;
        if (dm != 0) begin
            fr[n] = b_dpan[7:0]; n++;
            fr[n] = b_dpan[15:8]; n++;
            if (dm == 2) begin
                fr[n] = b_dshort[7:0]; n++;
                fr[n] = b_dshort[15:8]; n++;
            end
            if (dm == 3) for (int k = 0; k < 8; k++) begin
                fr[n] = ext[8*k +: 8]; n++;
            end
        end
        spp = (sm != 0) && !(cp != 0 && dm != 0);
        if (spp) begin
            fr[n] = b_span[7:0]; n++;
            fr[n] = b_span[15:8]; n++;
        end
        if (sm == 2) for (int k = 0; k < 2; k++) begin fr[n] = 8'h70 + 8'(k); n++; end
        if (sm == 3) for (int k = 0; k < 8; k++) begin fr[n] = 8'h90 + 8'(k); n++; end
        fr[n] = 8'hC3; n++;
        fr[n] = 8'h3C; n++;
    endtask

    // Send nb bytes of fr[] with length byte lb; sample the verdict.
    task automatic send(input int nb, input logic [7:0] lb, input logic f,
                        output logic [2:0] got);
        @(negedge clk); frm_start = 1'b1; byte_data = lb;
        @(negedge clk); frm_start = 1'b0;
        for (int i = 0; i < nb; i++) begin
            byte_vld = 1'b1; byte_data = fr[i];
            @(negedge clk);
        end
        byte_vld = 1'b0; frm_end = 1'b1; fcs_ok = f;
        @(negedge clk); frm_end = 1'b0;
        got = {frame_type_ok, addr_match, pkt_rcvd};
        @(negedge clk);
    endtask

    // Expected verdict from the requirements.
    function automatic logic [2:0] model(input int t, input int v, input int dm,
                                         input int sm, input int cp, input int lenv,
                                         input logic f);
        int cl;
        logic tok, integ, dok, rule, m;
        logic [15:0] spe;
        cl  = (t > 3) ? 4 : t;
        tok = cfg_type_accept[cl];
        if (cfg_accept_any) return {tok, 1'b0, tok & f};
        integ = (v != 3) && (dm != 1) && (sm != 1);
        dok = (dm == 0) || (((b_dpan == cfg_pan_id) || (b_dpan == 16'hFFFF)) &&
              ((dm == 2) ? ((b_dshort == cfg_short_addr) || (b_dshort == 16'hFFFF)) : b_ext_ok));
        spe = (cp != 0 && dm != 0) ? b_dpan : b_span;
        case (cl)
            0: rule = (dm == 0) && (sm >= 2) && ((cfg_pan_id == 16'hFFFF) || (spe == cfg_pan_id));
            2: rule = (lenv == 5);
            default: rule = (dm != 0 || sm != 0) && (dm != 0 || (cfg_pan_coord && spe == cfg_pan_id));
        endcase
        m = tok && integ && dok && rule;
        return {tok, m, m & f};
    endfunction

    task automatic sweep(input string tag);
        int idx = 0;
        logic [2:0] got;
        logic f;
        int vr;
        for (int t = 0; t < 8; t++)
        for (int v = 0; v < 4; v++)
        for (int dm = 0; dm < 4; dm++)
        for (int sm = 0; sm < 4; sm++)
        for (int cp = 0; cp < 2; cp++) begin
            vr = (idx + idx / 8 + idx / 64) & 3;
            f  = 1'(((idx / 2) ^ (idx / 16)) & 1);
            build(t, v, dm, sm, cp, vr);
            send(n, 8'(n), f, got);
            check($sformatf("%s R2 R3 R4 R5 R6 R7 R9 R11 R12 t=%0d v=%0d dm=%0d sm=%0d cp=%0d vr=%0d",
                            tag, t, v, dm, sm, cp, vr), got, model(t, v, dm, sm, cp, n, f));
            idx++;
        end
    endtask

    initial begin
        logic [2:0] got;
        repeat (3) @(negedge clk);
        check("R1 reset", {frame_type_ok, addr_match, pkt_rcvd}, 3'b000);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release", {frame_type_ok, addr_match, pkt_rcvd}, 3'b000);

        // R8: acknowledgement with bit 7 of the length byte set still passes.
        build(2, 0, 0, 0, 0, 0);
        send(n, 8'h85, 1'b1, got);
        check("R8 ack length masked", got, 3'b111);
        fr[5] = 8'h00; fr[6] = 8'h00;
        send(6, 8'd6, 1'b1, got);
        check("R8 ack length 6", got, 3'b100);

        // R10: truncated header.
        build(1, 1, 2, 2, 1, 0);
        send(7, 8'(n), 1'b1, got);
        check("R10 truncated header", got, 3'b100);
        send(n, 8'(n), 1'b1, got);
        check("R10 full header", got, 3'b111);

        // R12: FCS failure keeps the match but drops packet-received.
        send(n, 8'(n), 1'b0, got);
        check("R12 bad FCS", got, 3'b110);

        // R5: lowest extended address bit differs.
        build(1, 1, 3, 2, 0, 0);
        fr[5] = fr[5] ^ 8'h01;
        send(n, 8'(n), 1'b1, got);
        check("R5 ext address bit 0", got, 3'b100);

        // R6: node PAN set to broadcast accepts any beacon source PAN.
        cfg_pan_id = 16'hFFFF;
        build(0, 0, 0, 2, 0, 3);
        send(n, 8'(n), 1'b1, got);
        check("R6 beacon any source PAN", got, 3'b111);
        cfg_pan_id = 16'h1A2B;

        // R2: class disabled.
        cfg_type_accept = 5'b11101;
        build(1, 1, 2, 2, 1, 0);
        send(n, 8'(n), 1'b1, got);
        check("R2 data disabled", got, 3'b000);

        cfg_type_accept = 5'h1F; cfg_pan_coord = 1'b0; cfg_accept_any = 1'b0;
        sweep("A");
        cfg_type_accept = 5'b01011; cfg_pan_coord = 1'b1;
        sweep("B");
        cfg_type_accept = 5'b10110; cfg_accept_any = 1'b1;
        sweep("C");

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog R12: got=hang expected=finish");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule